// File: doc/BRIEF.md
# Per-Pin Edge Event Filter

This block watches a bank of general-purpose input pins and turns raw pin levels into per-pin edge events. Every time the sample strobe is high, it compares the present pin vector with the vector it kept from the previous strobe. For each pin it then applies an enable bit, a rising-select bit and a falling-select bit. A pin whose change matches its selection sets a sticky pending bit. Software or a servicing engine reads the pending vector and the index of the lowest pending pin, then clears the bits it has handled with a write-one-to-clear mask.

Pins are configured one at a time. A write names a pin and a trigger mode. Only the rising, falling and both-edge modes are accepted. Level-sensitive modes are refused and flagged. The pins are grouped into channels of `CHW` bits. A small state machine per channel records whether any pin of the channel is enabled. It has two states:

- `CH_IDLE`: no pin of the channel is enabled.
- `CH_ARMED`: at least one pin of the channel is enabled.

The transitions are:

- `CH_IDLE -> CH_ARMED` on an accepted write that enables a pin of the channel. This transition also reloads the channel's snapshot from the live pins, so an old difference cannot appear as an event.
- `CH_ARMED -> CH_IDLE` when the last enabled pin of the channel is switched off.

Top module: `edgefilt_top`

## Requirements
- R1: On a clock edge where `sample_stb` is 1, a pin whose snapshot bit is 0, whose current level is 1, and which is enabled with rising-select set, has its bit of `pend` set from the following cycle on.
- R2: On a clock edge where `sample_stb` is 1, a pin whose snapshot bit is 1, whose current level is 0, and which is enabled with falling-select set, has its bit of `pend` set from the following cycle on.
- R3: `cfg_mode` encodes 0 = off, 1 = rising, 2 = falling and 3 = both edges. In mode 3 either direction of change sets the pin's pending bit.
- R4: New pending bits appear only at an edge where `sample_stb` is 1. At every such edge the snapshot takes the full pin vector, whether or not any event fired.
- R5: Pending bits are sticky, and new events OR into them. At an edge where `clr_we` is 1, bits set in `clr_mask` are cleared. An event on a bit being cleared in the same cycle wins, and the bit stays 1.
- R6: A pin that is not enabled never sets its pending bit. Disabling a pin leaves an already set pending bit untouched.
- R7: A write with `cfg_mode` 4 or 5 (level high or level low) or 6 or 7 (reserved) is refused. Such a write leaves every mask unchanged and raises `cfg_err` for exactly the next cycle. An accepted write lowers `cfg_err` in the next cycle. An accepted write takes effect after its clock edge, so a strobe in the same cycle still uses the old masks.
- R8: An accepted write that enables a pin in a channel with no enabled pin reloads that channel's snapshot from `pins` at that edge. A write into a channel that already has an enabled pin does not reload it.
- R9: `first_valid` is 1 exactly when `pend` is nonzero. `first_idx` then gives the lowest set bit of `pend`.
- R10: After reset, `pend` is 0, `first_valid` and `cfg_err` are 0, all masks are clear, and the snapshot is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_stb | input | 1 | Evaluate pins against snapshot at this edge |
| pins | input | NPINS | Synchronized pin levels |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_pin | input | IDXW | Pin addressed by the write |
| cfg_mode | input | 3 | Trigger mode for the addressed pin |
| clr_we | input | 1 | Pending clear strobe |
| clr_mask | input | NPINS | Write-one-to-clear mask for `pend` |
| pend | output | NPINS | Sticky pending events |
| first_valid | output | 1 | Some pin is pending |
| first_idx | output | IDXW | Lowest pending pin |
| cfg_err | output | 1 | Previous cycle's write was refused |

## Verification
Two pairs of operations can land on the same edge.

- **Clear and event.** A pending bit can be cleared while a fresh event on the same pin is evaluated. The bench provokes this by clearing a bit while strobing the same rising edge that set it. It then expects the bit to stay 1.
- **Arming write and stale edge.** A configuration write can arm an idle channel while a stale pin difference is waiting. The bench raises a pin without a strobe, enables it, and then strobes. It expects no event. It contrasts this with the same sequence in a channel that is already armed, where the event must fire.

A long pseudo-random sequence mixes strobes, writes (including refused ones) and clears in every combination. It compares each cycle against a model built from the requirements.

// File: rtl/edgefilt_pkg.sv
package edgefilt_pkg;

    // Trigger mode encoding for configuration writes.
    typedef enum logic [2:0] {
        TRIG_OFF    = 3'd0,
        TRIG_RISE   = 3'd1,
        TRIG_FALL   = 3'd2,
        TRIG_BOTH   = 3'd3,
        TRIG_LVL_HI = 3'd4,
        TRIG_LVL_LO = 3'd5,
        TRIG_RSV6   = 3'd6,
        TRIG_RSV7   = 3'd7
    } trig_e;

    // Per-channel arming state.
    typedef enum logic {
        CH_IDLE  = 1'b0,
        CH_ARMED = 1'b1
    } chan_st_e;

    // Decoded form of a trigger mode.
    typedef struct packed {
        logic legal;
        logic en;
        logic rise;
        logic fall;
    } trig_dec_t;

    function automatic trig_dec_t decode_trig(logic [2:0] mode);
        trig_dec_t d;
        d = '0;
        unique case (trig_e'(mode))
            TRIG_OFF:  d = '{legal: 1'b1, en: 1'b0, rise: 1'b0, fall: 1'b0};
            TRIG_RISE: d = '{legal: 1'b1, en: 1'b1, rise: 1'b1, fall: 1'b0};
            TRIG_FALL: d = '{legal: 1'b1, en: 1'b1, rise: 1'b0, fall: 1'b1};
            TRIG_BOTH: d = '{legal: 1'b1, en: 1'b1, rise: 1'b1, fall: 1'b1};
            TRIG_LVL_HI, TRIG_LVL_LO, TRIG_RSV6, TRIG_RSV7: d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/edgefilt_cfg.sv
module edgefilt_cfg
    import edgefilt_pkg::*;
#(
    parameter int NPINS = 64,
    parameter int IDXW  = $clog2(NPINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDXW-1:0]  cfg_pin,
    input  logic [2:0]       cfg_mode,
    output logic [NPINS-1:0] en_q,
    output logic [NPINS-1:0] rise_q,
    output logic [NPINS-1:0] fall_q,
    output logic [NPINS-1:0] en_nxt,
    output logic             wr_ok,
    output logic             wr_arm,
    output logic             cfg_err
);

    trig_dec_t        dec;
    logic             pin_ok;
    logic [NPINS-1:0] rise_nxt;
    logic [NPINS-1:0] fall_nxt;

    always_comb begin
        dec    = decode_trig(cfg_mode);
        pin_ok = ({1'b0, cfg_pin} < (IDXW+1)'(NPINS));
        wr_ok  = cfg_we && dec.legal && pin_ok;
        wr_arm = wr_ok && dec.en;
    end

    always_comb begin
        en_nxt   = en_q;
        rise_nxt = rise_q;
        fall_nxt = fall_q;
        if (wr_ok) begin
            en_nxt[cfg_pin]   = dec.en;
            rise_nxt[cfg_pin] = dec.rise;
            fall_nxt[cfg_pin] = dec.fall;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= '0;
            rise_q  <= '0;
            fall_q  <= '0;
            cfg_err <= 1'b0;
        end else begin
            en_q    <= en_nxt;
            rise_q  <= rise_nxt;
            fall_q  <= fall_nxt;
            cfg_err <= cfg_we && !wr_ok;
        end
    end

    // R7: a refused write leaves all masks as they were
    assert_bad_write_keeps_cfg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !wr_ok) |=> (en_q == $past(en_q) && rise_q == $past(rise_q) && fall_q == $past(fall_q)));

    // R7: an enabled pin always carries at least one edge select (no level mode stored)
    assert_no_level_stored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q & ~(rise_q | fall_q)) == '0);

endmodule

// File: rtl/edgefilt_chan.sv
module edgefilt_chan
    import edgefilt_pkg::*;
#(
    parameter int CHW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_hit,
    input  logic [CHW-1:0] en_ch_q,
    input  logic [CHW-1:0] en_ch_nxt,
    output logic           refresh
);

    chan_st_e st_q;
    chan_st_e st_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_IDLE;
        else        st_q <= st_d;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_IDLE:  if (wr_hit)           st_d = CH_ARMED;
            CH_ARMED: if (en_ch_nxt == '0)  st_d = CH_IDLE;
        endcase
    end

    // Outputs: snapshot reload only on the arming transition
    always_comb begin
        refresh = 1'b0;
        unique case (st_q)
            CH_IDLE:  refresh = wr_hit;
            CH_ARMED: refresh = 1'b0;
        endcase
    end

    // R8: armed state mirrors presence of an enabled pin in the channel
    assert_armed_tracks_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_ARMED) == (en_ch_q != '0));

endmodule

// File: rtl/edgefilt_detect.sv
module edgefilt_detect #(
    parameter int NPINS = 64,
    parameter int CHW   = 32,
    parameter int NCH   = (NPINS + CHW - 1) / CHW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_stb,
    input  logic [NPINS-1:0] pins,
    input  logic [NPINS-1:0] en_q,
    input  logic [NPINS-1:0] rise_q,
    input  logic [NPINS-1:0] fall_q,
    input  logic [NCH-1:0]   refresh,
    input  logic             clr_we,
    input  logic [NPINS-1:0] clr_mask,
    output logic [NPINS-1:0] pend_q
);

    logic [NPINS-1:0] snap_q;
    logic [NPINS-1:0] snap_d;
    logic [NPINS-1:0] rise_ev;
    logic [NPINS-1:0] fall_ev;
    logic [NPINS-1:0] evt;
    logic [NPINS-1:0] pend_d;

    for (genvar i = 0; i < NPINS; i++) begin : g_snap
        localparam int CH = i / CHW;
        assign snap_d[i] = (sample_stb || refresh[CH]) ? pins[i] : snap_q[i];
    end

    always_comb begin
        rise_ev = ~snap_q & pins & en_q & rise_q;
        fall_ev = snap_q & ~pins & en_q & fall_q;
        evt     = sample_stb ? (rise_ev | fall_ev) : '0;
        pend_d  = (pend_q & ~(clr_we ? clr_mask : '0)) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
            pend_q <= '0;
        end else begin
            snap_q <= snap_d;
            pend_q <= pend_d;
        end
    end

    // R1: a qualified rising edge is pending after the strobe
    assert_rise_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> (($past(~snap_q & pins & en_q & rise_q) & ~pend_q) == '0));

    // R2: a qualified falling edge is pending after the strobe
    assert_fall_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> (($past(snap_q & ~pins & en_q & fall_q) & ~pend_q) == '0));

    // R4: no bit becomes pending without a strobe
    assert_set_only_on_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |=> ((pend_q & ~$past(pend_q)) == '0));

    // R4: every strobe loads the whole pin vector into the snapshot
    assert_snap_follows_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> (snap_q == $past(pins)));

    // R5: pending bits never drop without a clear
    assert_sticky_without_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> (($past(pend_q) & ~pend_q) == '0));

    // R6: a disabled pin cannot raise its pending bit
    assert_disabled_never_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(en_q)) == '0));

endmodule

// File: rtl/edgefilt_prio.sv
module edgefilt_prio #(
    parameter int NPINS = 64,
    parameter int IDXW  = $clog2(NPINS)
) (
    input  logic [NPINS-1:0] vec,
    output logic             valid,
    output logic [IDXW-1:0]  idx
);

    always_comb begin
        idx   = '0;
        valid = |vec;
        for (int i = NPINS - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDXW'(i);
        end
    end

endmodule

// File: rtl/edgefilt_top.sv
module edgefilt_top
    import edgefilt_pkg::*;
#(
    parameter int NPINS = 64,
    parameter int CHW   = 32,
    parameter int IDXW  = $clog2(NPINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_stb,
    input  logic [NPINS-1:0] pins,
    input  logic             cfg_we,
    input  logic [IDXW-1:0]  cfg_pin,
    input  logic [2:0]       cfg_mode,
    input  logic             clr_we,
    input  logic [NPINS-1:0] clr_mask,
    output logic [NPINS-1:0] pend,
    output logic             first_valid,
    output logic [IDXW-1:0]  first_idx,
    output logic             cfg_err
);

    localparam int NCH  = (NPINS + CHW - 1) / CHW;
    localparam int PADW = NCH * CHW;

    logic [NPINS-1:0] en_q;
    logic [NPINS-1:0] rise_q;
    logic [NPINS-1:0] fall_q;
    logic [NPINS-1:0] en_nxt;
    logic             wr_ok;
    logic             wr_arm;
    logic [PADW-1:0]  en_q_pad;
    logic [PADW-1:0]  en_nxt_pad;
    logic [NCH-1:0]   refresh;

    edgefilt_cfg #(.NPINS(NPINS), .IDXW(IDXW)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_pin  (cfg_pin),
        .cfg_mode (cfg_mode),
        .en_q     (en_q),
        .rise_q   (rise_q),
        .fall_q   (fall_q),
        .en_nxt   (en_nxt),
        .wr_ok    (wr_ok),
        .wr_arm   (wr_arm),
        .cfg_err  (cfg_err)
    );

    assign en_q_pad   = PADW'(en_q);
    assign en_nxt_pad = PADW'(en_nxt);

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic hit;
        assign hit = wr_arm && ((int'(cfg_pin) / CHW) == c);
        edgefilt_chan #(.CHW(CHW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_hit    (hit),
            .en_ch_q   (en_q_pad[c*CHW +: CHW]),
            .en_ch_nxt (en_nxt_pad[c*CHW +: CHW]),
            .refresh   (refresh[c])
        );
    end

    edgefilt_detect #(.NPINS(NPINS), .CHW(CHW), .NCH(NCH)) u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_stb (sample_stb),
        .pins       (pins),
        .en_q       (en_q),
        .rise_q     (rise_q),
        .fall_q     (fall_q),
        .refresh    (refresh),
        .clr_we     (clr_we),
        .clr_mask   (clr_mask),
        .pend_q     (pend)
    );

    edgefilt_prio #(.NPINS(NPINS), .IDXW(IDXW)) u_prio (
        .vec   (pend),
        .valid (first_valid),
        .idx   (first_idx)
    );

    // R9: reported index is set and nothing below it is
    assert_first_is_lowest_R9: assert property (@(posedge clk) disable iff (!rst_n)
        first_valid |-> (pend[first_idx] && ((pend & ((NPINS'(1) << first_idx) - NPINS'(1))) == '0)));

    // R9: valid flag agrees with pending vector
    assert_valid_matches_R9: assert property (@(posedge clk) disable iff (!rst_n)
        first_valid == (pend != '0));

    // R7: accepted writes never raise the error flag
    assert_ok_write_no_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && wr_ok) |=> !cfg_err);

endmodule

// File: tb/edgefilt_top_bench.sv
module edgefilt_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int CW = 4;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sample_stb = 1'b0;
    logic [N-1:0]  pins = '0;
    logic          cfg_we = 1'b0;
    logic [IW-1:0] cfg_pin = '0;
    logic [2:0]    cfg_mode = '0;
    logic          clr_we = 1'b0;
    logic [N-1:0]  clr_mask = '0;
    logic [N-1:0]  pend;
    logic          first_valid;
    logic [IW-1:0] first_idx;
    logic          cfg_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    logic [N-1:0] m_en = '0, m_rs = '0, m_fs = '0, m_snap = '0, m_pend = '0;
    logic         m_err = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    edgefilt_top #(.NPINS(N), .CHW(CW), .IDXW(IW)) u_edgefilt_top (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .pins(pins),
        .cfg_we(cfg_we), .cfg_pin(cfg_pin), .cfg_mode(cfg_mode),
        .clr_we(clr_we), .clr_mask(clr_mask), .pend(pend),
        .first_valid(first_valid), .first_idx(first_idx), .cfg_err(cfg_err)
    );

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic check_outputs(string tag);
        logic [IW-1:0] eidx;
        eidx = '0;
        for (int i = N - 1; i >= 0; i--) if (m_pend[i]) eidx = IW'(i);
        chk({tag, " pend"}, 32'(pend), 32'(m_pend));
        chk({tag, " R9 valid"}, 32'(first_valid), 32'(m_pend != '0));
        if (m_pend != '0) chk({tag, " R9 idx"}, 32'(first_idx), 32'(eidx));
        chk({tag, " R7 err"}, 32'(cfg_err), 32'(m_err));
    endtask

    // drive one cycle, advance model from the requirements, check
    task automatic step(string tag, logic stb, logic [N-1:0] p, logic we,
                        logic [IW-1:0] pin, logic [2:0] mode,
                        logic cw, logic [N-1:0] cm);
        logic         legal, arm;
        logic [N-1:0] ev;
        int           ch;
        sample_stb = stb; pins = p; cfg_we = we; cfg_pin = pin;
        cfg_mode = mode; clr_we = cw; clr_mask = cm;
        legal = (mode <= 3'd3);
        arm   = we && legal && (mode != 3'd0);
        ch    = int'(pin) / CW;
        ev    = stb ? ((~m_snap & p & m_en & m_rs) | (m_snap & ~p & m_en & m_fs)) : '0;
        @(posedge clk);
        #1;
        if (stb) m_snap = p;
        else if (arm && m_en[ch*CW +: CW] == '0) m_snap[ch*CW +: CW] = p[ch*CW +: CW];
        m_pend = (m_pend & ~(cw ? cm : '0)) | ev;
        if (we && legal) begin
            m_en[pin] = (mode != 3'd0);
            m_rs[pin] = (mode == 3'd1) || (mode == 3'd3);
            m_fs[pin] = (mode == 3'd2) || (mode == 3'd3);
        end
        m_err = we && !legal;
        check_outputs(tag);
    endtask

    task automatic idle_stb(string tag, logic [N-1:0] p);
        step(tag, 1'b1, p, 1'b0, '0, 3'd0, 1'b0, '0);
    endtask

    task automatic cfg(string tag, logic [IW-1:0] pin, logic [2:0] mode, logic [N-1:0] p);
        step(tag, 1'b0, p, 1'b1, pin, mode, 1'b0, '0);
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        chk("R10 pend", 32'(pend), 0);
        chk("R10 valid", 32'(first_valid), 0);
        chk("R10 err", 32'(cfg_err), 0);
        rst_n = 1'b1;

        // R7: level and reserved modes refused, masks unchanged
        cfg("R7 lvl hi", 3'd2, 3'd4, '0);
        cfg("R7 lvl lo", 3'd2, 3'd5, '0);
        cfg("R7 rsv", 3'd2, 3'd7, '0);
        idle_stb("R7 no effect", 8'h04);
        chk("R7 masks untouched", 32'(pend), 0);
        idle_stb("R7 back", 8'h00);

        // R1: rising on pin 0, R2: falling on pin 5, R3: both on pin 6
        cfg("R1 cfg", 3'd0, 3'd1, '0);
        cfg("R2 cfg", 3'd5, 3'd2, '0);
        cfg("R3 cfg", 3'd6, 3'd3, '0);
        idle_stb("R1 rise", 8'h21);
        chk("R1 pin0 set", 32'(pend[0]), 1);
        chk("R2 pin5 rise ignored", 32'(pend[5]), 0);
        idle_stb("R2 fall", 8'h40);
        chk("R2 pin5 set", 32'(pend[5]), 1);
        chk("R3 pin6 rise", 32'(pend[6]), 1);
        step("R5 clear all", 1'b0, 8'h40, 1'b0, '0, 3'd0, 1'b1, 8'hFF);
        idle_stb("R3 fall", 8'h00);
        chk("R3 pin6 fall", 32'(pend), 32'h40);

        // R5: clear and event on the same bit in the same cycle
        step("R5 clr", 1'b0, 8'h00, 1'b0, '0, 3'd0, 1'b1, 8'hFF);
        step("R5 race", 1'b1, 8'h01, 1'b0, '0, 3'd0, 1'b1, 8'h01);
        chk("R5 event beats clear", 32'(pend[0]), 1);

        // R6: disable pin 0, pending stays, new edges ignored
        cfg("R6 off", 3'd0, 3'd0, 8'h01);
        idle_stb("R6 low", 8'h00);
        idle_stb("R6 high", 8'h01);
        chk("R6 pending kept", 32'(pend), 32'h01);
        step("R6 clr", 1'b0, 8'h01, 1'b0, '0, 3'd0, 1'b1, 8'hFF);

        // R8: arming reload on idle channel 1 (pins 4..7 enabled: 5,6 -> disable first)
        cfg("R8 off5", 3'd5, 3'd0, 8'h00);
        cfg("R8 off6", 3'd6, 3'd0, 8'h00);
        idle_stb("R8 base", 8'h00);
        step("R8 raise", 1'b0, 8'h10, 1'b0, '0, 3'd0, 1'b0, '0);
        cfg("R8 arm", 3'd4, 3'd1, 8'h10);
        idle_stb("R8 stale", 8'h10);
        chk("R8 no false event", 32'(pend), 0);
        // channel already armed: no reload
        idle_stb("R8 base2", 8'h00);
        step("R8 raise2", 1'b0, 8'h20, 1'b0, '0, 3'd0, 1'b0, '0);
        cfg("R8 second", 3'd5, 3'd1, 8'h20);
        idle_stb("R8 armed", 8'h20);
        chk("R8 armed channel fires", 32'(pend), 32'h20);

        // R7: config write with strobe in same cycle uses old masks
        step("R7 clr", 1'b0, 8'h00, 1'b0, '0, 3'd0, 1'b1, 8'hFF);
        step("R7 same cycle", 1'b1, 8'h80, 1'b1, 3'd7, 3'd1, 1'b0, '0);
        chk("R7 old masks", 32'(pend[7]), 0);

        // R4/R9 sweep of mixed traffic
        lfsr = 32'h1ACE_B00C;
        for (int k = 0; k < 4000; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step("R4 sweep", lfsr[0], lfsr[8:1], lfsr[11:9] == 3'd0, lfsr[14:12],
                 lfsr[17:15], lfsr[20:18] == 3'd0, lfsr[28:21]);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule